// File: doc/BRIEF.md
# Extended 16-bit Register-Pair Execution Unit

This block carries out a set of extra 16-bit instructions that sit beside the base instruction set of a small 8-bit accumulator processor with BC, DE, HL and SP register pairs. The core presents one fetched opcode with `start` while the block is idle. It also presents up to two immediate bytes, the current pairs, the carry, overflow (V) and K flags, and the return address. The block answers with updated DE, HL and SP values, updated flags, and a branch request with its target. When the instruction is one of its own, it also raises `hit`.

Register-only work (pair subtract, shifts, offset loads, conditional jumps, a restart that is not taken, and opcodes the block does not own) completes one cycle after `start`. The indexed HL store, the indexed HL load and a taken restart move bytes over a byte-wide request/ready memory port. Each byte waits for `mem_ready`. The controller moves through the states IDLE, WR_LO, WR_HI, RD_LO, RD_HI, PUSH_HI and PUSH_LO. Its transitions are: IDLE to WR_LO on a store start, and WR_LO to WR_HI to IDLE. IDLE goes to RD_LO on a load start, then RD_LO to RD_HI to IDLE. IDLE goes to PUSH_HI on a taken restart, then PUSH_HI to PUSH_LO to IDLE. Each step out of a memory state happens on a cycle where `mem_ready` is high. IDLE stays in IDLE for every other start.

Top module: `xpair_exec`

## Requirements
- R1: After reset `done`, `hit`, `br_take` and `mem_req` are 0, and the DE, HL and SP outputs and the three flag outputs are 0.
- R2: Opcode 0x08 yields HL = HL − BC modulo 2^16. Carry is the borrow (HL < BC unsigned), V is the signed overflow of the subtraction, and K = V XOR result bit 15.
- R3: Opcode 0x10 shifts HL right by one and keeps bit 15 unchanged. Carry takes the old bit 0, and V and K are unchanged.
- R4: Opcode 0x18 shifts DE left by one with bit 0 cleared. Carry takes the old DE bit 15, and V and K are unchanged.
- R5: Opcode 0x28 loads DE with HL + imm_lo and opcode 0x38 loads DE with SP + imm_lo. imm_lo is unsigned, the sum is modulo 2^16, and HL, SP and the flags are unchanged.
- R6: Opcode 0xD9 writes L to address DE and then H to address DE+1. Registers and flags are unchanged.
- R7: Opcode 0xED reads L from address DE and then H from address DE+1 into HL.
- R8: While `mem_req` is high and `mem_ready` is low, the request, the write enable, the address and the write data hold. Exactly one byte moves per ready cycle.
- R9: Opcode 0xFD requests a branch when K is 1 and opcode 0xDD requests one when K is 0. The target is {imm_hi, imm_lo}.
- R10: Opcode 0xCB with V = 1 writes the return address high byte at SP−1 and then the low byte at SP−2. It then gives SP−2, and a branch to 0x0040. With V = 0 it moves no data and requests no branch.
- R11: Opcode 0x00 completes with `hit` = 1 and nothing changed. Opcodes 0x20, 0x30 and any opcode not listed here complete with `hit` = 0, nothing changed, and no memory access.
- R12: Every instruction that is not a memory instruction raises `done` for exactly one cycle, in the cycle right after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opcode and operands valid; accepted only while idle |
| opcode | input | 8 | Fetched opcode byte |
| imm_lo | input | 8 | First immediate byte (offset or target low) |
| imm_hi | input | 8 | Second immediate byte (target high) |
| ret_pc | input | 16 | Return address pushed by a taken restart |
| bc_in | input | 16 | Current BC pair |
| de_in | input | 16 | Current DE pair |
| hl_in | input | 16 | Current HL pair |
| sp_in | input | 16 | Current stack pointer |
| c_in | input | 1 | Current carry |
| v_in | input | 1 | Current overflow flag |
| k_in | input | 1 | Current K flag |
| de_out | output | 16 | Resulting DE |
| hl_out | output | 16 | Resulting HL |
| sp_out | output | 16 | Resulting SP |
| c_out | output | 1 | Resulting carry |
| v_out | output | 1 | Resulting overflow flag |
| k_out | output | 1 | Resulting K flag |
| done | output | 1 | One-cycle completion pulse; results valid |
| hit | output | 1 | Opcode belonged to this block |
| br_take | output | 1 | Branch requested |
| br_target | output | 16 | Branch target |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_ready | input | 1 | Byte transfer completes this cycle |

## Verification
A controller stuck in a wrong state would show at the memory port within one ready cycle. The request would stay high after the second byte, or the address would go to DE+1 before DE, or the high push byte would land at SP−2. A wrong captured flag or pair would show in the single `done` cycle of the instruction concerned. It could appear as a borrow that fails to set, a sign bit that does not hold through the shift, or a jump that follows the inverse of K. No state lasts longer than the instruction that created it, so every fault is visible by that instruction's `done`.

// File: rtl/xpx_pkg.sv
package xpx_pkg;
    localparam int unsigned PAIR_W = 16;
    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_RSTV = 8'hCB;
    localparam logic [BYTE_W-1:0] OP_SHLX = 8'hD9;
    localparam logic [BYTE_W-1:0] OP_JNK  = 8'hDD;
    localparam logic [BYTE_W-1:0] OP_LHLX = 8'hED;
    localparam logic [BYTE_W-1:0] OP_JK   = 8'hFD;

    typedef enum logic [3:0] {
        K_NONE, K_NOP, K_PSUB, K_SHR_HL, K_SHL_DE, K_DE_HLO, K_DE_SPO,
        K_ST_HL, K_LD_HL, K_JMP_K, K_JMP_NK, K_RST_V
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_WR_LO, S_WR_HI, S_RD_LO, S_RD_HI, S_PUSH_HI, S_PUSH_LO
    } state_e;
endpackage

// File: rtl/xpx_decode.sv
module xpx_decode
    import xpx_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output kind_e             kind
);
    logic [1:0] f_top;
    logic [2:0] f_mid;
    logic [2:0] f_bot;

    always_comb begin
        f_top = opcode[7:6];
        f_mid = opcode[5:3];
        f_bot = opcode[2:0];
        kind  = K_NONE;
        if (f_top == 2'd0 && f_bot == 3'd0) begin
            unique case (f_mid)
                3'd0:    kind = K_NOP;
                3'd1:    kind = K_PSUB;
                3'd2:    kind = K_SHR_HL;
                3'd3:    kind = K_SHL_DE;
                3'd5:    kind = K_DE_HLO;
                3'd7:    kind = K_DE_SPO;
                default: kind = K_NONE;   // mask read / mask set pass through
            endcase
        end else begin
            unique case (opcode)
                OP_RSTV: kind = K_RST_V;
                OP_SHLX: kind = K_ST_HL;
                OP_JNK:  kind = K_JMP_NK;
                OP_LHLX: kind = K_LD_HL;
                OP_JK:   kind = K_JMP_K;
                default: kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/xpx_alu.sv
module xpx_alu
    import xpx_pkg::*;
(
    input  kind_e             kind,
    input  logic [BYTE_W-1:0] imm,
    input  logic [PAIR_W-1:0] bc,
    input  logic [PAIR_W-1:0] de,
    input  logic [PAIR_W-1:0] hl,
    input  logic [PAIR_W-1:0] sp,
    input  logic              c,
    input  logic              v,
    input  logic              k,
    output logic [PAIR_W-1:0] de_n,
    output logic [PAIR_W-1:0] hl_n,
    output logic              c_n,
    output logic              v_n,
    output logic              k_n
);
    logic [PAIR_W:0]   diff;
    logic [PAIR_W-1:0] imm_ext;

    always_comb begin
        diff    = {1'b0, hl} - {1'b0, bc};
        imm_ext = {{(PAIR_W-BYTE_W){1'b0}}, imm};
        de_n = de;
        hl_n = hl;
        c_n  = c;
        v_n  = v;
        k_n  = k;
        unique case (kind)
            K_PSUB: begin
                hl_n = diff[PAIR_W-1:0];
                c_n  = diff[PAIR_W];
                v_n  = (hl[PAIR_W-1] != bc[PAIR_W-1]) &&
                       (diff[PAIR_W-1] != hl[PAIR_W-1]);
                k_n  = v_n ^ diff[PAIR_W-1];
            end
            K_SHR_HL: begin
                hl_n = {hl[PAIR_W-1], hl[PAIR_W-1:1]};
                c_n  = hl[0];
            end
            K_SHL_DE: begin
                de_n = {de[PAIR_W-2:0], 1'b0};
                c_n  = de[PAIR_W-1];
            end
            K_DE_HLO: de_n = hl + imm_ext;
            K_DE_SPO: de_n = sp + imm_ext;
            default: ;
        endcase
    end
endmodule

// File: rtl/xpair_exec.sv
module xpair_exec
    import xpx_pkg::*;
#(
    parameter logic [PAIR_W-1:0] RST_VEC = 16'h0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [BYTE_W-1:0] imm_lo,
    input  logic [BYTE_W-1:0] imm_hi,
    input  logic [PAIR_W-1:0] ret_pc,
    input  logic [PAIR_W-1:0] bc_in,
    input  logic [PAIR_W-1:0] de_in,
    input  logic [PAIR_W-1:0] hl_in,
    input  logic [PAIR_W-1:0] sp_in,
    input  logic              c_in,
    input  logic              v_in,
    input  logic              k_in,
    output logic [PAIR_W-1:0] de_out,
    output logic [PAIR_W-1:0] hl_out,
    output logic [PAIR_W-1:0] sp_out,
    output logic              c_out,
    output logic              v_out,
    output logic              k_out,
    output logic              done,
    output logic              hit,
    output logic              br_take,
    output logic [PAIR_W-1:0] br_target,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PAIR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam logic [PAIR_W-1:0] ONE = PAIR_W'(1);
    localparam logic [PAIR_W-1:0] TWO = PAIR_W'(2);

    kind_e             kind;
    kind_e             last_kind;
    state_e            state, state_nx;
    logic [PAIR_W-1:0] de_a, hl_a;
    logic              c_a, v_a, k_a;
    logic [PAIR_W-1:0] de_q, hl_q, sp_q, ret_q, tgt_q;
    logic              c_q, v_q, k_q, done_q, hit_q, take_q;

    xpx_decode u_dec (.opcode(opcode), .kind(kind));

    xpx_alu u_alu (
        .kind(kind), .imm(imm_lo), .bc(bc_in), .de(de_in), .hl(hl_in), .sp(sp_in),
        .c(c_in), .v(v_in), .k(k_in),
        .de_n(de_a), .hl_n(hl_a), .c_n(c_a), .v_n(v_a), .k_n(k_a)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) begin
                if (kind == K_ST_HL)              state_nx = S_WR_LO;
                else if (kind == K_LD_HL)         state_nx = S_RD_LO;
                else if (kind == K_RST_V && v_in) state_nx = S_PUSH_HI;
            end
            S_WR_LO:   if (mem_ready) state_nx = S_WR_HI;
            S_WR_HI:   if (mem_ready) state_nx = S_IDLE;
            S_RD_LO:   if (mem_ready) state_nx = S_RD_HI;
            S_RD_HI:   if (mem_ready) state_nx = S_IDLE;
            S_PUSH_HI: if (mem_ready) state_nx = S_PUSH_LO;
            S_PUSH_LO: if (mem_ready) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // memory port
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = de_q;
        mem_wdata = hl_q[BYTE_W-1:0];
        unique case (state)
            S_IDLE:    begin mem_req = 1'b0; mem_we = 1'b0; end
            S_WR_LO:   ;
            S_WR_HI:   begin mem_addr = de_q + ONE; mem_wdata = hl_q[PAIR_W-1:BYTE_W]; end
            S_RD_LO:   mem_we = 1'b0;
            S_RD_HI:   begin mem_we = 1'b0; mem_addr = de_q + ONE; end
            S_PUSH_HI: begin mem_addr = sp_q - ONE; mem_wdata = ret_q[PAIR_W-1:BYTE_W]; end
            S_PUSH_LO: begin mem_addr = sp_q - TWO; mem_wdata = ret_q[BYTE_W-1:0]; end
            default:   begin mem_req = 1'b0; mem_we = 1'b0; end
        endcase
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q <= '0; hl_q <= '0; sp_q <= '0; ret_q <= '0; tgt_q <= '0;
            c_q <= 1'b0; v_q <= 1'b0; k_q <= 1'b0;
            done_q <= 1'b0; hit_q <= 1'b0; take_q <= 1'b0;
            last_kind <= K_NONE;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    last_kind <= kind;
                    hit_q  <= (kind != K_NONE);
                    de_q   <= de_a;
                    hl_q   <= hl_a;
                    sp_q   <= sp_in;
                    c_q    <= c_a;
                    v_q    <= v_a;
                    k_q    <= k_a;
                    ret_q  <= ret_pc;
                    take_q <= 1'b0;
                    tgt_q  <= '0;
                    if (kind == K_JMP_K || kind == K_JMP_NK) begin
                        take_q <= (kind == K_JMP_K) ? k_in : !k_in;
                        tgt_q  <= {imm_hi, imm_lo};
                    end
                    if (!(kind == K_ST_HL || kind == K_LD_HL || (kind == K_RST_V && v_in)))
                        done_q <= 1'b1;
                end
                S_WR_LO, S_RD_LO, S_PUSH_HI: begin
                    if (state == S_RD_LO && mem_ready) hl_q[BYTE_W-1:0] <= mem_rdata;
                end
                S_WR_HI: if (mem_ready) done_q <= 1'b1;
                S_RD_HI: if (mem_ready) begin
                    hl_q[PAIR_W-1:BYTE_W] <= mem_rdata;
                    done_q <= 1'b1;
                end
                S_PUSH_LO: if (mem_ready) begin
                    sp_q   <= sp_q - TWO;
                    take_q <= 1'b1;
                    tgt_q  <= RST_VEC;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign de_out    = de_q;
    assign hl_out    = hl_q;
    assign sp_out    = sp_q;
    assign c_out     = c_q;
    assign v_out     = v_q;
    assign k_out     = k_q;
    assign done      = done_q;
    assign hit       = hit_q;
    assign br_take   = take_q;
    assign br_target = tgt_q;

    // R8: a stalled request holds still
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11: no memory traffic while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !mem_req);

    // R3: the kept sign bit is duplicated into bit 14
    a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last_kind == K_SHR_HL) |-> (hl_out[PAIR_W-1] == hl_out[PAIR_W-2]));

    // R4: DE shift leaves bit 0 clear
    a_r4_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last_kind == K_SHL_DE) |-> !de_out[0]);

    // R9: jump-on-K follows the (unchanged) K flag
    a_r9_jk_follows_k: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last_kind == K_JMP_K) |-> (br_take == k_out));

    // R10: a taken restart lowers SP by two
    a_r10_sp_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && br_take && last_kind == K_RST_V) |-> (sp_out == $past(sp_out) - TWO));
endmodule

// File: tb/xpair_exec_tb.sv
module xpair_exec_tb;
    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  ilo;
        logic [7:0]  ihi;
        logic [15:0] bc;
        logic [15:0] de;
        logic [15:0] hl;
        logic [15:0] sp;
        logic        c;
        logic        v;
        logic        k;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{8'h08, 8'h00, 8'h00, 16'h0235, 16'h1111, 16'h1234, 16'h2000, 1'b1, 1'b1, 1'b1}, // R2 plain
        '{8'h08, 8'h00, 8'h00, 16'h0001, 16'h1111, 16'h8000, 16'h2000, 1'b0, 1'b0, 1'b0}, // R2 overflow
        '{8'h08, 8'h00, 8'h00, 16'h0002, 16'h1111, 16'h0001, 16'h2000, 1'b0, 1'b0, 1'b0}, // R2 borrow
        '{8'h10, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h8003, 16'h2000, 1'b0, 1'b1, 1'b0}, // R3 negative
        '{8'h10, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h4002, 16'h2000, 1'b1, 1'b0, 1'b1}, // R3 positive
        '{8'h18, 8'h00, 8'h00, 16'h0000, 16'h8001, 16'h0000, 16'h2000, 1'b0, 1'b0, 1'b0}, // R4 carry out
        '{8'h18, 8'h00, 8'h00, 16'h0000, 16'h4000, 16'h0000, 16'h2000, 1'b1, 1'b1, 1'b1}, // R4 no carry
        '{8'h28, 8'h20, 8'h00, 16'h0000, 16'h0000, 16'hFFF0, 16'h2000, 1'b0, 1'b0, 1'b0}, // R5 wrap
        '{8'h38, 8'hFF, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h1000, 1'b1, 1'b0, 1'b1}, // R5 sp
        '{8'h00, 8'h00, 8'h00, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1'b1, 1'b0, 1'b1}, // R11 nop
        '{8'h20, 8'h00, 8'h00, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1'b0, 1'b1, 1'b0}, // R11 reserved
        '{8'h30, 8'h00, 8'h00, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1'b1, 1'b1, 1'b1}, // R11 reserved
        '{8'h01, 8'h00, 8'h00, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1'b0, 1'b0, 1'b0}, // R11 foreign
        '{8'hFD, 8'h34, 8'h12, 16'h0000, 16'h0000, 16'h0000, 16'h2000, 1'b0, 1'b0, 1'b1}, // R9 jk taken
        '{8'hFD, 8'h34, 8'h12, 16'h0000, 16'h0000, 16'h0000, 16'h2000, 1'b0, 1'b0, 1'b0}, // R9 jk not
        '{8'hDD, 8'hCD, 8'hAB, 16'h0000, 16'h0000, 16'h0000, 16'h2000, 1'b0, 1'b0, 1'b0}, // R9 jnk taken
        '{8'hCB, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0090, 1'b0, 1'b0, 1'b1}  // R10 not taken
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, imm_lo = '0, imm_hi = '0;
    logic [15:0] ret_pc = '0, bc_in = '0, de_in = '0, hl_in = '0, sp_in = '0;
    logic        c_in = 1'b0, v_in = 1'b0, k_in = 1'b0;
    logic [15:0] de_out, hl_out, sp_out, br_target, mem_addr;
    logic        c_out, v_out, k_out, done, hit, br_take, mem_req, mem_we;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready;
    logic        stall_en = 1'b0;
    logic [1:0]  cyc = '0;

    logic [7:0]  mem [256];
    logic [15:0] wlog [4];
    int          wcnt = 0;
    int          rcnt = 0;
    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;

    always #5 clk = ~clk;

    xpair_exec u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm_lo(imm_lo), .imm_hi(imm_hi),
        .ret_pc(ret_pc), .bc_in(bc_in), .de_in(de_in), .hl_in(hl_in), .sp_in(sp_in),
        .c_in(c_in), .v_in(v_in), .k_in(k_in),
        .de_out(de_out), .hl_out(hl_out), .sp_out(sp_out), .c_out(c_out), .v_out(v_out), .k_out(k_out),
        .done(done), .hit(hit), .br_take(br_take), .br_target(br_target),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    assign mem_ready = !stall_en || (cyc == 2'b11);
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        cyc <= cyc + 2'd1;
        cycles <= cycles + 1;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                if (wcnt < 4) wlog[wcnt] <= mem_addr;
                wcnt <= wcnt + 1;
            end else begin
                rcnt <= rcnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model written from the requirements
    task automatic model(input vec_t t, output logic [15:0] e_de, output logic [15:0] e_hl,
                         output logic [3:0] e_fl, output logic e_hit, output logic e_tk,
                         output logic [15:0] e_tg);
        int s;
        logic [15:0] r;
        logic ov;
        e_de = t.de; e_hl = t.hl; e_fl = {t.c, t.v, t.k, 1'b0};
        e_hit = 1'b1; e_tk = 1'b0; e_tg = 16'h0000;
        case (t.op)
            8'h08: begin
                r  = t.hl - t.bc;
                s  = int'($signed(t.hl)) - int'($signed(t.bc));
                ov = (s > 32767) || (s < -32768);
                e_hl = r;
                e_fl = {(t.hl < t.bc), ov, ov ^ r[15], 1'b0};
            end
            8'h10: begin e_hl = (t.hl >> 1) | (t.hl & 16'h8000); e_fl[3] = t.hl[0]; end
            8'h18: begin e_de = t.de << 1; e_fl[3] = t.de[15]; end
            8'h28: e_de = t.hl + {8'h00, t.ilo};
            8'h38: e_de = t.sp + {8'h00, t.ilo};
            8'h00: ;
            8'hFD: begin e_tk = t.k;  e_tg = {t.ihi, t.ilo}; end
            8'hDD: begin e_tk = !t.k; e_tg = {t.ihi, t.ilo}; end
            8'hCB: ;
            default: e_hit = 1'b0;
        endcase
    endtask

    task automatic drive(input vec_t t);
        opcode = t.op; imm_lo = t.ilo; imm_hi = t.ihi;
        bc_in = t.bc; de_in = t.de; hl_in = t.hl; sp_in = t.sp;
        c_in = t.c; v_in = t.v; k_in = t.k;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    initial begin
        logic [15:0] e_de, e_hl, e_tg;
        logic [3:0]  e_fl;
        logic        e_hit, e_tk;
        vec_t        t;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 br_take", br_take, 0);
        chk("R1 hit", hit, 0);
        chk("R1 pairs", {de_out, hl_out}, 32'h0);
        chk("R1 sp/flags", {sp_out, 13'h0, c_out, v_out, k_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of register-only instructions
        for (int n = 0; n < NV; n++) begin
            t = VECS[n];
            drive(t);
            start = 1'b1;
            wcnt = 0; rcnt = 0;
            @(negedge clk);
            start = 1'b0;
            model(t, e_de, e_hl, e_fl, e_hit, e_tk, e_tg);
            chk("R12 done one cycle after start", done, 1);
            chk("R2 R3 R4 R5 R11 hl", hl_out, e_hl);
            chk("R4 R5 R11 de", de_out, e_de);
            chk("R5 R10 sp unchanged", sp_out, t.sp);
            chk("R2 R3 R4 flags c,v,k", {c_out, v_out, k_out}, e_fl[3:1]);
            chk("R11 hit", hit, e_hit);
            chk("R9 R10 branch take", br_take, e_tk);
            if (e_tk) chk("R9 branch target", br_target, e_tg);
            @(negedge clk);
            chk("R12 done single pulse", done, 0);
            chk("R11 R10 no memory traffic", wcnt + rcnt, 0);
        end

        // R6 store with stalls: L at DE, then H at DE+1
        stall_en = 1'b1;
        t = '{8'hD9, 8'h00, 8'h00, 16'h0000, 16'h0040, 16'hBEEF, 16'h2000, 1'b1, 1'b0, 1'b1};
        drive(t); wcnt = 0; rcnt = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        chk("R6 done", done, 1);
        chk("R8 two writes", wcnt, 2);
        chk("R6 first addr", wlog[0], 16'h0040);
        chk("R6 second addr", wlog[1], 16'h0041);
        chk("R6 low byte", mem[8'h40], 8'hEF);
        chk("R6 high byte", mem[8'h41], 8'hBE);
        chk("R6 hl unchanged", hl_out, 16'hBEEF);
        chk("R6 flags unchanged", {c_out, v_out, k_out}, 3'b101);
        @(negedge clk);

        // R7 load with stalls
        mem[8'h80] = 8'h34; mem[8'h81] = 8'h12;
        t = '{8'hED, 8'h00, 8'h00, 16'h0000, 16'h0080, 16'hFFFF, 16'h2000, 1'b0, 1'b0, 1'b0};
        drive(t); wcnt = 0; rcnt = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        chk("R7 done", done, 1);
        chk("R7 hl loaded", hl_out, 16'h1234);
        chk("R8 two reads", rcnt, 2);
        chk("R7 no writes", wcnt, 0);
        @(negedge clk);
        stall_en = 1'b0;

        // R10 taken restart
        ret_pc = 16'h1357;
        t = '{8'hCB, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0090, 1'b0, 1'b1, 1'b0};
        drive(t); wcnt = 0; rcnt = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        chk("R10 done", done, 1);
        chk("R10 take", br_take, 1);
        chk("R10 vector", br_target, 16'h0040);
        chk("R10 sp", sp_out, 16'h008E);
        chk("R10 push order hi", wlog[0], 16'h008F);
        chk("R10 push order lo", wlog[1], 16'h008E);
        chk("R10 high byte", mem[8'h8F], 8'h13);
        chk("R10 low byte", mem[8'h8E], 8'h57);
        @(negedge clk);
        chk("R10 done single pulse", done, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule